// File: doc/BRIEF.md
# Reference Frequency Range Monitor

This block judges whether a reference clock of nominally 2.048 MHz runs close enough to its expected rate. It runs entirely on a local 20 MHz master clock. The reference is brought into that domain through a two-flop synchronizer, and its rising edges are detected there. The block counts those edges over a fixed gate of master cycles and compares the count with the nominal value. The result drives a single in-range flag. Because every measurement is taken against the master clock, any error in that clock moves the whole window by the same amount.

The flag has two thresholds, which give it hysteresis. A deviation at or below the accept limit sets the flag. A deviation above the reject limit clears it. A deviation between the two limits leaves the flag as it was. The signed deviation of the last gate is also driven out for observation. Both outputs change only at the end of a gate. The outputs are plain status pins with no handshake.

The default gate is 2,000,000 master cycles, which is 100 ms. The default nominal count is 204,800 edges. The accept limit is 20 counts, about 100 ppm, and the reject limit is 27 counts, about 130 ppm. All four values are parameters.

Top module: `ref_freq_mon`

## Requirements
- R1: While reset is high, and until the first gate ends, `ref_ok` is 0 and `offset` is 0.
- R2: A gate lasts exactly GATE_CYCLES master cycles. The first gate begins on the first clock edge after reset is released. `ref_ok` and `offset` change only on the last edge of a gate and hold their values at all other times.
- R3: At the end of a gate, `offset` becomes the number of reference rising edges counted in that gate minus NOMINAL. It is a two's-complement value.
- R4: If the absolute deviation of a gate is at most ACCEPT, `ref_ok` becomes 1 (in range). This includes a deviation of exactly ACCEPT.
- R5: If the absolute deviation of a gate is greater than REJECT, `ref_ok` becomes 0 (out of range). A reference held at a constant level gives a deviation of -NOMINAL.
- R6: If the absolute deviation is greater than ACCEPT and at most REJECT, `ref_ok` keeps its previous value. This applies whether that value was 0 or 1, and includes a deviation of exactly REJECT.
- R7: Negative deviations are judged on the same limits as positive ones.
- R8: The reference input is passed through two flip-flops before edge detection. Only low-to-high transitions are counted, and each transition counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| ref_ok | output | 1 | 1 = reference in range, 0 = out of range |
| offset | output | CNT_W+1 | Signed deviation of the last gate from NOMINAL, in edge counts |

## Verification
A reference transition sampled at a clock edge is counted two edges later, because the synchronizer and the edge detector both lie on the path. The stimulus therefore places every transition more than a hundred cycles away from either end of a gate. This makes the count for each gate exact.

Each gate's results appear on the edge that closes the gate. The bench drives exactly GATE_CYCLES cycles per gate from the release of reset. It samples both outputs at the falling edge after the closing edge. It also samples them one cycle before the close, where they must still hold the previous gate's values.

// File: rtl/ref_freq_mon_pkg.sv
package ref_freq_mon_pkg;

  typedef enum logic {
    RANGE_OUT = 1'b0,
    RANGE_IN  = 1'b1
  } range_t;

  // Two-limit decision: accept at or below lo, reject above hi, else hold.
  function automatic range_t next_range(input range_t cur, input logic below_lo,
                                        input logic above_hi);
    if (below_lo)      return RANGE_IN;
    else if (above_hi) return RANGE_OUT;
    else               return cur;
  endfunction

endpackage

// File: rtl/rfm_sync_edge.sv
module rfm_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/rfm_gate_counter.sv
module rfm_gate_counter #(
  parameter int unsigned GATE_CYCLES = 2000000,
  parameter int unsigned CNT_W       = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  output logic             done,
  output logic [CNT_W-1:0] count
);
  localparam int unsigned GATE_W = $clog2(GATE_CYCLES);

  logic [GATE_W-1:0] tick_q;
  logic [CNT_W-1:0]  acc_q;
  logic              last;

  assign last = (tick_q == GATE_W'(GATE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      acc_q  <= '0;
    end else if (last) begin
      tick_q <= '0;
      acc_q  <= '0;
    end else begin
      tick_q <= tick_q + 1'b1;
      acc_q  <= acc_q + CNT_W'(rise);
    end
  end

  // Final count includes an edge seen in the closing cycle.
  assign done  = last & ~rst;
  assign count = acc_q + CNT_W'(rise);
endmodule

// File: rtl/rfm_window.sv
module rfm_window
  import ref_freq_mon_pkg::*;
#(
  parameter int unsigned NOMINAL = 204800,
  parameter int unsigned ACCEPT  = 20,
  parameter int unsigned REJECT  = 27,
  parameter int unsigned CNT_W   = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    done,
  input  logic [CNT_W-1:0]        count,
  output logic                    ref_ok,
  output logic signed [CNT_W:0]   offset
);
  localparam int unsigned OFS_W = CNT_W + 1;

  logic signed [OFS_W-1:0] dev;
  logic [OFS_W-1:0]        mag;
  range_t                  state_q;

  assign dev = $signed({1'b0, count}) - $signed(OFS_W'(NOMINAL));
  assign mag = dev[OFS_W-1] ? OFS_W'(-dev) : OFS_W'(dev);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RANGE_OUT;
      offset  <= '0;
    end else if (done) begin
      state_q <= next_range(state_q, mag <= OFS_W'(ACCEPT), mag > OFS_W'(REJECT));
      offset  <= dev;
    end
  end

  assign ref_ok = (state_q == RANGE_IN);
endmodule

// File: rtl/ref_freq_mon.sv
module ref_freq_mon #(
  parameter int unsigned GATE_CYCLES = 2000000,
  parameter int unsigned NOMINAL     = 204800,
  parameter int unsigned ACCEPT      = 20,
  parameter int unsigned REJECT      = 27,
  parameter int unsigned CNT_W       = $clog2(GATE_CYCLES / 2 + 2)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ref_in,
  output logic                  ref_ok,
  output logic signed [CNT_W:0] offset
);
  logic             rise;
  logic             gate_done;
  logic [CNT_W-1:0] gate_count;

  rfm_sync_edge u_sync (
    .clk(clk), .rst(rst), .async_in(ref_in), .rise(rise)
  );

  rfm_gate_counter #(.GATE_CYCLES(GATE_CYCLES), .CNT_W(CNT_W)) u_gate (
    .clk(clk), .rst(rst), .rise(rise), .done(gate_done), .count(gate_count)
  );

  rfm_window #(.NOMINAL(NOMINAL), .ACCEPT(ACCEPT), .REJECT(REJECT), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst(rst), .done(gate_done), .count(gate_count),
    .ref_ok(ref_ok), .offset(offset)
  );
endmodule

// File: rtl/ref_freq_mon_chk.sv
module ref_freq_mon_chk #(
  parameter int unsigned GATE_CYCLES = 2000000,
  parameter int unsigned NOMINAL     = 204800,
  parameter int unsigned ACCEPT      = 20,
  parameter int unsigned REJECT      = 27,
  parameter int unsigned CNT_W       = 20
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  done,
  input logic [CNT_W-1:0]      count,
  input logic                  ref_ok,
  input logic signed [CNT_W:0] offset
);
  int unsigned cyc;
  int          dev;
  int          mag;

  always_ff @(posedge clk) begin
    if (rst || cyc == GATE_CYCLES - 1) cyc <= 0;
    else                               cyc <= cyc + 1;
  end

  assign dev = int'(count) - int'(NOMINAL);
  assign mag = (dev < 0) ? -dev : dev;

  // R2: gate close comes exactly every GATE_CYCLES cycles
  p_gate_len_r2: assert property (@(posedge clk) disable iff (rst)
    (cyc == GATE_CYCLES - 1) == done);

  // R2: outputs hold between gate closes
  p_hold_out_r2: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(ref_ok) && $stable(offset)));

  // R3: published offset equals count minus nominal
  p_offset_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> (int'(offset) == $past(dev)));

  // R4: accept limit sets the flag
  p_accept_r4: assert property (@(posedge clk) disable iff (rst)
    (done && mag <= int'(ACCEPT)) |=> ref_ok);

  // R5: reject limit clears the flag
  p_reject_r5: assert property (@(posedge clk) disable iff (rst)
    (done && mag > int'(REJECT)) |=> !ref_ok);

  // R6: between limits the flag is kept
  p_band_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done && mag > int'(ACCEPT) && mag <= int'(REJECT)) |=> $stable(ref_ok));
endmodule

bind ref_freq_mon ref_freq_mon_chk #(
  .GATE_CYCLES(GATE_CYCLES), .NOMINAL(NOMINAL), .ACCEPT(ACCEPT),
  .REJECT(REJECT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .done(gate_done), .count(gate_count),
  .ref_ok(ref_ok), .offset(offset)
);

// File: tb/ref_freq_mon_tb.sv
module ref_freq_mon_tb;
  localparam int unsigned GATE = 4000;
  localparam int unsigned NOM  = 1000;
  localparam int unsigned ACC  = 20;
  localparam int unsigned REJ  = 27;
  localparam int unsigned CW   = $clog2(GATE / 2 + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic ref_ok;
  logic signed [CW:0] offset;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  bit model_ok = 0;
  int model_ofs = 0;

  always #10 clk = ~clk;

  ref_freq_mon #(.GATE_CYCLES(GATE), .NOMINAL(NOM), .ACCEPT(ACC), .REJECT(REJ)) u_dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .ref_ok(ref_ok), .offset(offset)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one gate with k rising edges (period 3 cycles) placed from cycle 100.
  task automatic run_gate(input int k, input string req);
    int dev, mag;
    for (int pos = 0; pos < int'(GATE); pos++) begin
      ref_in = (pos >= 100) && (pos < 100 + 3 * k) && ((pos - 100) % 3 == 0);
      if (pos == int'(GATE) - 1) begin
        check({req, "/R2 hold ofs"}, int'(offset), model_ofs);
        check({req, "/R2 hold ok"}, int'(ref_ok), int'(model_ok));
      end
      @(posedge clk);
      @(negedge clk);
    end
    dev = k - int'(NOM);
    mag = (dev < 0) ? -dev : dev;
    if (mag <= int'(ACC)) model_ok = 1;
    else if (mag > int'(REJ)) model_ok = 0;
    model_ofs = dev;
    check({req, "/R3 ofs"}, int'(offset), model_ofs);
    check({req, " ok"}, int'(ref_ok), int'(model_ok));
  endtask

  task automatic t_reset();
    check("R1 ok", int'(ref_ok), 0);
    check("R1 ofs", int'(offset), 0);
  endtask

  task automatic t_nominal();   run_gate(1000, "R4 nominal R8"); endtask
  task automatic t_band_hi1();  run_gate(1024, "R6 band from 1"); endtask
  task automatic t_rej_edge();  run_gate(1028, "R5 just above"); endtask
  task automatic t_band_lo0();  run_gate(1021, "R6 band from 0"); run_gate(1027, "R6 edge from 0"); endtask
  task automatic t_acc_edge();  run_gate(1020, "R4 exact accept"); endtask
  task automatic t_band_edge(); run_gate(1027, "R6 exact reject from 1"); endtask
  task automatic t_negative();
    run_gate(980, "R7 neg accept");
    run_gate(975, "R7 neg band");
    run_gate(972, "R7 neg reject");
    run_gate(975, "R7 neg band from 0");
    run_gate(985, "R7 neg in");
  endtask
  task automatic t_static();    run_gate(0, "R5 static ref"); endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_nominal();
    t_band_hi1();
    t_rej_edge();
    t_band_lo0();
    t_acc_edge();
    t_band_edge();
    t_negative();
    t_static();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule